// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block arbitrates six interrupt request sources for an 8-bit microcontroller core. Software sets up an enable register, which holds a master enable bit and one enable bit per source, and a priority register, which gives each source a one-bit level: high or low. Each cycle the block looks at the request flags that are currently enabled. It picks one by level first and then by a fixed polling order within the level. It raises a request with an 8-bit vector address toward the CPU.

The block keeps one in-service bit per level. Nesting works like this: a high-level request preempts a low-level handler, and a handler blocks every new request at its own level or below. An acknowledge from the CPU marks the served level busy. A return-from-interrupt frees the highest busy level, so an interrupted low-level handler carries on after the high-level one ends. When a source is acknowledged, the block pulses a clear strobe for that source if the source is one whose flag hardware clears.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset both configuration registers read 0, both in-service bits are 0, and no request is raised, even with all request inputs high.
- R2: A write with `cfg_sel`=0 loads the enable register and a write with `cfg_sel`=1 loads the priority register. Enable bit 6 and priority bits 7:6 are reserved and always read back as 0.
- R3: Sources are numbered 0 to 5 as external 0, timer 0, external 1, timer 1, serial, timer 2. Enable bit i and priority bit i belong to source i. A source is eligible only when its request input is high, its enable bit is 1 and enable bit 7 (the master enable) is 1.
- R4: Among eligible sources at the same level, the one with the lowest number wins.
- R5: Priority bit 1 selects the high level. An eligible high-level source always wins over every low-level source, whatever their numbers.
- R6: The vector output equals 03h plus 8 times the winning source number (03h, 0Bh, 13h, 1Bh, 23h, 2Bh).
- R7: A high-level winner is raised only while the high in-service bit is 0. A low-level winner is raised only while both in-service bits are 0. Otherwise the request waits and no request is raised.
- R8: An acknowledge that comes while a request is raised and return-from-interrupt is low sets the in-service bit of the served level at the next edge. Any other acknowledge leaves the in-service bits unchanged.
- R9: A return-from-interrupt clears the high in-service bit if it is set, and otherwise clears the low one.
- R10: In the same cycle as an accepted acknowledge, `flag_clr` bit i pulses for the served source i when i is timer 0 or timer 1. It also pulses when i is external 0 or external 1 and that input's `edge_mode` bit is 1. It never pulses for serial or timer 2, or for a level-mode external source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = enable register, 1 = priority register |
| cfg_wdata | input | 8 | Configuration write data |
| en_rd | output | 8 | Enable register read-back |
| pri_rd | output | 8 | Priority register read-back |
| src_req | input | 6 | Request flags, bit i = source i |
| edge_mode | input | 2 | Bit 0/1: external 0/1 is transition-triggered |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector address of the selected source |
| irq_ack | input | 1 | CPU acknowledge of the raised request |
| irq_reti | input | 1 | CPU return-from-interrupt |
| flag_clr | output | 6 | One-cycle clear strobe per source |
| in_svc | output | 2 | In-service bits, bit 1 = high level |

## Verification
The bench sets up a low-level handler that gets preempted by a high-level source that is later in the polling order. A design that ranked by source number alone would vector the low one, or would refuse the preemption. While a low-level handler is running, a pending low-level request must stay silent; a design that compared only the high in-service bit would raise it. Two returns from interrupt in a row must undo the nesting in order. A design that cleared the wrong bit would leave the high level busy. The clear strobe is checked for an external source in both trigger modes and for the serial source, so a mask that ignores the trigger mode or clears every source shows up.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC  = 6;
  localparam int unsigned IDX_W    = $clog2(NUM_SRC);
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned VEC_BASE = 3;
  localparam int unsigned VEC_STEP = 8;
  localparam int unsigned REG_W    = 8;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;

  typedef struct packed {
    logic             valid;
    lvl_e             lvl;
    logic [IDX_W-1:0] idx;
  } pick_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] pri_q
);
  localparam logic [REG_W-1:0] EN_MASK  = 8'hBF;
  localparam logic [REG_W-1:0] PRI_MASK = 8'h3F;

  logic [REG_W-1:0] en_d, pri_d;
  logic             en_ld, pri_ld;

  always_comb begin
    en_ld  = cfg_we && !cfg_sel;
    pri_ld = cfg_we &&  cfg_sel;
    en_d   = cfg_wdata & EN_MASK;
    pri_d  = cfg_wdata & PRI_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
    end else begin
      if (en_ld)  en_q  <= en_d;
      if (pri_ld) pri_q <= pri_d;
    end
  end

  AST_RSV_EN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    en_ld |=> (en_q[6] == 1'b0)); // R2
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               glb_en,
  input  logic [NUM_SRC-1:0] src_pri,
  input  logic [1:0]         in_svc,
  input  logic [1:0]         edge_mode,
  input  logic               ack_fire,
  output logic               irq_req,
  output lvl_e               sel_lvl,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [NUM_SRC-1:0] flag_clr
);
  localparam logic [NUM_SRC-1:0] TMR_CLR = 6'b001010;

  logic [NUM_SRC-1:0] elig, hi_set, lo_set, clr_mask;
  pick_t              hi_pick, lo_pick, win;

  function automatic pick_t first_of(input logic [NUM_SRC-1:0] v, input lvl_e l);
    pick_t p;
    p.valid = 1'b0;
    p.lvl   = l;
    p.idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.valid = 1'b1;
        p.idx   = IDX_W'(i);
      end
    end
    return p;
  endfunction

  always_comb begin
    elig    = src_req & src_en & {NUM_SRC{glb_en}};
    hi_set  = elig & src_pri;
    lo_set  = elig & ~src_pri;
    hi_pick = first_of(hi_set, LVL_HI);
    lo_pick = first_of(lo_set, LVL_LO);
    win     = '0;
    if (hi_pick.valid && !in_svc[1])
      win = hi_pick;
    else if (!hi_pick.valid && lo_pick.valid && in_svc == 2'b00)
      win = lo_pick;
    irq_req = win.valid;
    sel_lvl = win.lvl;
    irq_vec = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(win.idx);
  end

  always_comb begin
    clr_mask    = TMR_CLR;
    clr_mask[0] = edge_mode[0];
    clr_mask[2] = edge_mode[1];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
    assign flag_clr[g] = ack_fire && (win.idx == IDX_W'(g)) && clr_mask[g];
  end

  AST_HI_ADMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && sel_lvl == LVL_HI) |-> !in_svc[1]); // R7
  AST_LO_ADMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && sel_lvl == LVL_LO) |-> (in_svc == 2'b00)); // R7
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_req); // R3
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr)); // R10
  AST_CLR_NO_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[4] == 1'b0) && (flag_clr[5] == 1'b0)); // R10
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_fire,
  input  lvl_e       ack_lvl,
  input  logic       reti,
  output logic [1:0] svc_q
);
  logic [1:0] svc_d;
  logic       svc_ld;

  always_comb begin
    svc_d  = svc_q;
    svc_ld = ack_fire || reti;
    if (reti) begin
      if (svc_q[1]) svc_d[1] = 1'b0;
      else          svc_d[0] = 1'b0;
    end else if (ack_fire) begin
      svc_d[ack_lvl] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      svc_q <= '0;
    else if (svc_ld) svc_q <= svc_d;
  end

  AST_ACK_MARKS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && ack_lvl == LVL_HI) |=> svc_q[1]); // R8
  AST_ACK_MARKS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && ack_lvl == LVL_LO) |=> svc_q[0]); // R8
  AST_RETI_POP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && svc_q[1]) |=> (!svc_q[1] && svc_q[0] == $past(svc_q[0]))); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_fire && !reti) |=> $stable(svc_q)); // R8
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] en_rd,
  output logic [7:0] pri_rd,
  input  logic [5:0] src_req,
  input  logic [1:0] edge_mode,
  output logic       irq_req,
  output logic [7:0] irq_vec,
  input  logic       irq_ack,
  input  logic       irq_reti,
  output logic [5:0] flag_clr,
  output logic [1:0] in_svc
);
  logic [REG_W-1:0] en_q, pri_q;
  logic             ack_fire;
  lvl_e             sel_lvl;

  irq_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .en_q      (en_q),
    .pri_q     (pri_q)
  );

  assign ack_fire = irq_ack && irq_req && !irq_reti;

  irq_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .src_en    (en_q[NUM_SRC-1:0]),
    .glb_en    (en_q[REG_W-1]),
    .src_pri   (pri_q[NUM_SRC-1:0]),
    .in_svc    (in_svc),
    .edge_mode (edge_mode),
    .ack_fire  (ack_fire),
    .irq_req   (irq_req),
    .sel_lvl   (sel_lvl),
    .irq_vec   (irq_vec),
    .flag_clr  (flag_clr)
  );

  irq_inservice u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_fire (ack_fire),
    .ack_lvl  (sel_lvl),
    .reti     (irq_reti),
    .svc_q    (in_svc)
  );

  assign en_rd  = en_q;
  assign pri_rd = pri_q;

  AST_CLR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_clr) |-> (irq_ack && !irq_reti)); // R10
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cfg_sel;
  logic [7:0] cfg_wdata;
  logic [7:0] en_rd, pri_rd;
  logic [5:0] src_req;
  logic [1:0] edge_mode;
  logic       irq_req;
  logic [7:0] irq_vec;
  logic       irq_ack, irq_reti;
  logic [5:0] flag_clr;
  logic [1:0] in_svc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .en_rd(en_rd), .pri_rd(pri_rd),
    .src_req(src_req), .edge_mode(edge_mode), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_reti(irq_reti),
    .flag_clr(flag_clr), .in_svc(in_svc)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic sel, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic set_req(input logic [5:0] r);
    @(negedge clk); src_req = r; #1;
  endtask

  task automatic pulse_ack(input string tag, input logic [5:0] exp_clr);
    @(negedge clk); irq_ack = 1'b1; #1;
    chk(tag, flag_clr, exp_clr);
    @(negedge clk); irq_ack = 1'b0; #1;
  endtask

  task automatic pulse_reti();
    @(negedge clk); irq_reti = 1'b1;
    @(negedge clk); irq_reti = 1'b0; #1;
  endtask

  task automatic t_reset();
    src_req = 6'h3F; #1;
    chk("R1 en_rd", en_rd, 0);
    chk("R1 pri_rd", pri_rd, 0);
    chk("R1 in_svc", in_svc, 0);
    chk("R1 irq_req", irq_req, 0);
  endtask

  task automatic t_regs();
    wr_cfg(1'b0, 8'hFF); #1;
    chk("R2 enable readback", en_rd, 8'hBF);
    wr_cfg(1'b1, 8'hFF); #1;
    chk("R2 priority readback", pri_rd, 8'h3F);
    wr_cfg(1'b1, 8'h00);
  endtask

  task automatic t_global();
    wr_cfg(1'b0, 8'h3F);
    set_req(6'h3F);
    chk("R3 master off", irq_req, 0);
    wr_cfg(1'b0, 8'hBB);
    set_req(6'b000100);
    chk("R3 source disabled", irq_req, 0);
    wr_cfg(1'b0, 8'hBF); #1;
    chk("R3 source enabled", irq_req, 1);
    chk("R6 vector ext1", irq_vec, 8'h13);
  endtask

  task automatic t_poll();
    set_req(6'b110100);
    chk("R4 lowest number wins", irq_vec, 8'h13);
    set_req(6'b100000);
    chk("R6 vector timer2", irq_vec, 8'h2B);
    set_req(6'b011000);
    chk("R6 vector timer1", irq_vec, 8'h1B);
  endtask

  task automatic t_level();
    wr_cfg(1'b1, 8'h20);
    set_req(6'h3F);
    chk("R5 high level beats order", irq_vec, 8'h2B);
    wr_cfg(1'b1, 8'h00);
  endtask

  task automatic t_nest();
    edge_mode = 2'b11;
    wr_cfg(1'b1, 8'h08);
    set_req(6'b000001);
    pulse_ack("R10 ext0 edge clears", 6'b000001);
    chk("R8 low level marked", in_svc, 2'b01);
    chk("R7 low blocked by low", irq_req, 0);
    set_req(6'b001001);
    chk("R7 high preempts", irq_req, 1);
    chk("R7 preempt vector", irq_vec, 8'h1B);
    pulse_ack("R10 timer1 clears", 6'b001000);
    chk("R8 high level marked", in_svc, 2'b11);
    chk("R7 all blocked", irq_req, 0);
    pulse_reti();
    chk("R9 high popped first", in_svc, 2'b01);
    pulse_reti();
    chk("R9 low popped", in_svc, 2'b00);
    wr_cfg(1'b1, 8'h00);
  endtask

  task automatic t_clear();
    edge_mode = 2'b00;
    set_req(6'b000001);
    pulse_ack("R10 ext0 level mode no clear", 6'b000000);
    pulse_reti();
    set_req(6'b010000);
    pulse_ack("R10 serial no clear", 6'b000000);
    pulse_reti();
    set_req(6'b000010);
    pulse_ack("R10 timer0 clears", 6'b000010);
    pulse_reti();
    chk("R9 back to idle", in_svc, 0);
  endtask

  task automatic t_ack_ignored();
    set_req(6'b000000);
    pulse_ack("R10 no clear without request", 6'b000000);
    chk("R8 ack without request", in_svc, 0);
    set_req(6'b000010);
    @(negedge clk); irq_ack = 1'b1; irq_reti = 1'b1; #1;
    chk("R10 no clear with reti", flag_clr, 0);
    @(negedge clk); irq_ack = 1'b0; irq_reti = 1'b0; #1;
    chk("R8 ack with reti ignored", in_svc, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    src_req = '0; edge_mode = '0; irq_ack = 1'b0; irq_reti = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_regs();
    t_global();
    t_poll();
    t_level();
    t_nest();
    t_clear();
    t_ack_ignored();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule